// File: doc/BRIEF.md
# Read-Triggered SAR Conversion Controller

This block sequences an 8-bit successive-approximation conversion for a serially accessed analog front end. A pulse from the bus read logic, raised once a read has been addressed and acknowledged, starts a conversion. The block then walks a trial code on its DAC output from the most significant bit down, one bit per clock. After each trial it reads back a single comparator bit that says whether the sampled input is at or above the trial code. The comparator and DAC are abstract ports; the analog parts and the bus engine are outside the block.

The finished code goes into a data register. That register is the byte the bus engine shifts out on the next read. While the bus sends the current register contents, the new conversion runs in parallel, so each read returns the result of the conversion before it. After reset the register holds the midscale code 0x80.

A two-bit channel pointer selects one of four inputs. Software can load it while the block is idle, and it can step forward after each conversion, wrapping from 3 to 0. A channel marked differential reports its result as two's complement instead of plain binary.

Top module: `rdtrig_sar_ctrl`

## Requirements
- R1: After reset, rd_data_o is 0x80, chan_o is 0, busy_o and done_o are 0 and dac_code_o is 0.
- R2: start_i high at a clock edge while busy_o is 0 starts a conversion: busy_o is 1 from the next cycle, and the first trial on dac_code_o is 0x80.
- R3: A conversion lasts exactly 8 clock cycles with busy_o high. Each cycle tries one bit, MSB first, on top of the bits already resolved. At the end of the cycle the bit is kept if cmp_i is 1 (input at or above the trial code) and cleared otherwise. On the edge ending the eighth step, busy_o falls and done_o goes high for exactly one cycle. dac_code_o is 0 while idle.
- R4: rd_data_o changes only on the edge that raises done_o. Between conversions it keeps the last result, so the byte present when a read starts is the previous conversion's result.
- R5: With diff_i low when the conversion starts, the stored result is the resolved code as plain unsigned binary.
- R6: With diff_i high when the conversion starts, the stored result is two's complement, equal to the resolved code plus 128 modulo 256 (MSB inverted). diff_i changes during a conversion have no effect.
- R7: With auto_inc_i high when the conversion starts, chan_o advances by one on the edge that raises done_o, and wraps from 3 to 0.
- R8: With auto_inc_i low when the conversion starts, chan_o is unchanged by the conversion.
- R9: chan_load_i high at an edge while idle loads chan_sel_i into chan_o for the next cycle. chan_load_i is ignored while busy_o is 1, and chan_o is stable throughout a conversion.
- R10: start_i while busy_o is 1 is ignored: the running conversion keeps its length and its result, and no new conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start pulse from the read front end |
| diff_i | input | 1 | Selected channel is differential (sampled at start) |
| auto_inc_i | input | 1 | Step the channel pointer after this conversion (sampled at start) |
| chan_load_i | input | 1 | Load chan_sel_i into the channel pointer |
| chan_sel_i | input | 2 | Channel number to load |
| cmp_i | input | 1 | Comparator: 1 when input is at or above dac_code_o |
| dac_code_o | output | 8 | Trial code for the DAC during a conversion |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe when a result is stored |
| chan_o | output | 2 | Current channel pointer |
| rd_data_o | output | 8 | Data register: byte returned by the next read |

## Verification
A wrong trial mask or a wrong resolved bit shows on dac_code_o in the very step it happens. It then shows as a wrong byte on rd_data_o at the done strobe, eight cycles after the start. A wrong step count moves done_o off the eighth cycle at once. A stale or mis-latched mode flag only shows at the end of the conversion, as a byte with the wrong MSB or a channel pointer that did or did not step. The result is only read on the next start, so the bench also checks the data register at each read to catch a register that drifts between conversions.

// File: rtl/rdtrig_sar_pkg.sv
package rdtrig_sar_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;

  // conversion modes captured when a conversion is accepted
  typedef struct packed {
    logic diff;
    logic ainc;
  } conv_mode_t;

endpackage

// File: rtl/rdtrig_sar_seq.sv
module rdtrig_sar_seq
  import rdtrig_sar_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              last_o,
  output logic              fin_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] resolved_o
);

  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  sar_state_e        state_q;
  logic [CODE_W-1:0] work_q;
  logic [CODE_W-1:0] trial_q;

  // keep the trial bit when the comparator says input >= trial code
  function automatic logic [CODE_W-1:0] resolve_bit(
    input logic [CODE_W-1:0] work,
    input logic [CODE_W-1:0] trial,
    input logic              keep
  );
    return keep ? (work | trial) : work;
  endfunction

  assign busy_o     = (state_q == ST_CONV);
  assign accept_o   = start_i && !busy_o;
  assign last_o     = busy_o && trial_q[0];
  assign dac_code_o = busy_o ? (work_q | trial_q) : '0;
  assign resolved_o = resolve_bit(work_q, trial_q, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      trial_q <= '0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= last_o;
      if (accept_o) begin
        state_q <= ST_CONV;
        work_q  <= '0;
        trial_q <= MSB_MASK;
      end else if (busy_o) begin
        work_q  <= resolved_o;
        trial_q <= trial_q >> 1;
        if (trial_q[0]) begin
          state_q <= ST_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/rdtrig_chan_ptr.sv
module rdtrig_chan_ptr #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en_i,
  input  logic [CH_W-1:0] load_val_i,
  input  logic            step_i,
  output logic [CH_W-1:0] chan_o
);

  logic [CH_W-1:0] next_ch;

  generate
    if ((1 << CH_W) == NUM_CH) begin : g_pow2_wrap
      assign next_ch = chan_o + CH_W'(1);
    end else begin : g_cmp_wrap
      assign next_ch = (chan_o == CH_W'(NUM_CH - 1)) ? '0 : chan_o + CH_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_o <= '0;
    end else if (load_en_i) begin
      chan_o <= load_val_i;
    end else if (step_i) begin
      chan_o <= next_ch;
    end
  end

endmodule

// File: rtl/rdtrig_result_reg.sv
module rdtrig_result_reg #(
  parameter int                CODE_W     = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = {1'b1, {(CODE_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              diff_i,
  input  logic [CODE_W-1:0] raw_i,
  output logic [CODE_W-1:0] data_o
);

  // offset binary to two's complement: flip the sign position
  function automatic logic [CODE_W-1:0] present(
    input logic [CODE_W-1:0] raw,
    input logic              diff
  );
    return diff ? {~raw[CODE_W-1], raw[CODE_W-2:0]} : raw;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= RESET_CODE;
    end else if (wr_i) begin
      data_o <= present(raw_i, diff_i);
    end
  end

endmodule

// File: rtl/rdtrig_sar_ctrl.sv
module rdtrig_sar_ctrl
  import rdtrig_sar_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      diff_i,
  input  logic                      auto_inc_i,
  input  logic                      chan_load_i,
  input  logic [$clog2(NUM_CH)-1:0] chan_sel_i,
  input  logic                      cmp_i,
  output logic [CODE_W-1:0]         dac_code_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [$clog2(NUM_CH)-1:0] chan_o,
  output logic [CODE_W-1:0]         rd_data_o
);

  localparam int CH_W = $clog2(NUM_CH);

  logic              accept;
  logic              last_step;
  logic [CODE_W-1:0] resolved;
  conv_mode_t        mode_q;
  logic              load_en;
  logic              ptr_step;

  rdtrig_sar_seq #(.CODE_W(CODE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .busy_o    (busy_o),
    .accept_o  (accept),
    .last_o    (last_step),
    .fin_o     (done_o),
    .dac_code_o(dac_code_o),
    .resolved_o(resolved)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (accept) begin
      mode_q.diff <= diff_i;
      mode_q.ainc <= auto_inc_i;
    end
  end

  assign load_en  = chan_load_i && !busy_o;
  assign ptr_step = last_step && mode_q.ainc;

  rdtrig_chan_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en_i (load_en),
    .load_val_i(chan_sel_i),
    .step_i    (ptr_step),
    .chan_o    (chan_o)
  );

  rdtrig_result_reg #(.CODE_W(CODE_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (last_step),
    .diff_i(mode_q.diff),
    .raw_i (resolved),
    .data_o(rd_data_o)
  );

endmodule

// File: rtl/rdtrig_sar_ctrl_chk.sv
module rdtrig_sar_ctrl_chk #(
  parameter int CODE_W = 8,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [CODE_W-1:0] rd_data_o,
  input logic [CH_W-1:0]   chan_o
);

  localparam int CNT_W = $clog2(CODE_W + 1) + 1;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + CNT_W'(1);
    else busy_cnt <= '0;
  end

  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_cnt == CNT_W'(CODE_W))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3

  AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == '0)); // R3

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (dac_code_o == {1'b1, {(CODE_W-1){1'b0}}})); // R2

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rd_data_o)); // R4

  AST_CHAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(chan_o)); // R9

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

endmodule

bind rdtrig_sar_ctrl rdtrig_sar_ctrl_chk #(.CODE_W(CODE_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .dac_code_o(dac_code_o),
  .rd_data_o (rd_data_o),
  .chan_o    (chan_o)
);

// File: tb/rdtrig_sar_ctrl_bench.sv
module rdtrig_sar_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       diff_i = 1'b0;
  logic       auto_inc_i = 1'b0;
  logic       chan_load_i = 1'b0;
  logic [1:0] chan_sel_i = 2'd0;
  logic       cmp_i;
  logic [7:0] dac_code_o;
  logic       busy_o;
  logic       done_o;
  logic [1:0] chan_o;
  logic [7:0] rd_data_o;

  logic [7:0] ain [4];

  int checks = 0;
  int errors = 0;

  logic [7:0] model_data;
  logic [1:0] model_ch;

  always #5 clk = ~clk;

  // ideal comparator on the selected analog level
  assign cmp_i = (ain[chan_o] >= dac_code_o);

  rdtrig_sar_ctrl u_rdtrig_sar_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .diff_i     (diff_i),
    .auto_inc_i (auto_inc_i),
    .chan_load_i(chan_load_i),
    .chan_sel_i (chan_sel_i),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .chan_o     (chan_o),
    .rd_data_o  (rd_data_o)
  );

  function automatic logic [7:0] expect_code(input logic [7:0] level, input logic diff);
    int v;
    v = diff ? (int'(level) + 128) % 256 : int'(level);
    return v[7:0];
  endfunction

  function automatic logic [1:0] expect_next(input logic [1:0] ch);
    int v;
    v = (int'(ch) + 1) % 4;
    return v[1:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_conv(input bit load, input logic [1:0] sel, input bit diff,
                         input bit ainc, input bit spurious);
    logic [7:0] exp;
    @(negedge clk);
    if (load) begin
      chan_load_i = 1'b1;
      chan_sel_i  = sel;
      @(negedge clk);
      chan_load_i = 1'b0;
      model_ch = sel;
      check(chan_o == sel, "R9 load idle", chan_o, sel);
    end
    check(rd_data_o == model_data, "R4 previous result at read", rd_data_o, model_data);
    diff_i     = diff;
    auto_inc_i = ainc;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    check(dac_code_o == 8'h80, "R2 first trial", dac_code_o, 8'h80);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (k == 2) begin
        diff_i     = ~diff;
        auto_inc_i = ~ainc;
      end
      if (spurious && k == 3) start_i = 1'b1;
      if (spurious && k == 4) start_i = 1'b0;
      if (spurious && k == 5) begin
        chan_load_i = 1'b1;
        chan_sel_i  = ~model_ch;
      end
      if (spurious && k == 6) chan_load_i = 1'b0;
      if (k == 7) begin
        check(busy_o == 1'b1 && done_o == 1'b0, "R3 still busy at step 8", {busy_o, done_o}, 2);
        start_i = 1'b0;
        chan_load_i = 1'b0;
      end
    end
    @(negedge clk);
    exp = expect_code(ain[model_ch], diff);
    check(done_o == 1'b1 && busy_o == 1'b0, "R3 done after 8 steps", {busy_o, done_o}, 1);
    if (diff) check(rd_data_o == exp, "R6 differential result", rd_data_o, exp);
    else      check(rd_data_o == exp, "R5 single-ended result", rd_data_o, exp);
    model_data = exp;
    if (ainc) begin
      model_ch = expect_next(model_ch);
      check(chan_o == model_ch, "R7 pointer advance", chan_o, model_ch);
    end else begin
      check(chan_o == model_ch, "R8 pointer held", chan_o, model_ch);
    end
    @(negedge clk);
    if (spurious) check(busy_o == 1'b0, "R10 start while busy ignored", busy_o, 0);
    check(done_o == 1'b0 && dac_code_o == 8'h00, "R3 done one cycle, idle dac", {done_o, dac_code_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    ain[0] = 8'd0; ain[1] = 8'd255; ain[2] = 8'h80; ain[3] = 8'h7F;
    model_data = 8'h80;
    model_ch   = 2'd0;
    repeat (3) @(negedge clk);
    check(rd_data_o == 8'h80, "R1 reset data", rd_data_o, 8'h80);
    check(chan_o == 2'd0 && busy_o == 1'b0 && done_o == 1'b0 && dac_code_o == 8'h00,
          "R1 reset state", {chan_o, busy_o, done_o, dac_code_o}, 0);
    rst_n = 1'b1;

    // directed corners: all four channels in turn with stepping
    do_conv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    do_conv(1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    do_conv(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    do_conv(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
    // wrap from channel 3 to 0
    do_conv(1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
    do_conv(1'b1, 2'd1, 1'b1, 1'b0, 1'b1);

    for (int n = 0; n < 40; n++) begin
      for (int c = 0; c < 4; c++) ain[c] = 8'($urandom);
      do_conv(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    check(rd_data_o == model_data, "R4 result held while idle", rd_data_o, model_data);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule